// File: doc/BRIEF.md
# Sequential Shift-Add Linear Interpolator

This block blends two unsigned fractions with a fractional weight, using the same loop as a shift-and-add multiplier. Both operands and the weight are N-bit fractions in [0,1], and the all-ones pattern stands for 1.0. A plain multiplier adds an operand only when the current weight bit is 1. Here every step adds something. A weight bit of 1 adds the shifted `b`, and a weight bit of 0 adds the shifted `a`. After each add the weight moves right by one place and both operands move left by one place. The 2N-bit sum therefore equals `b*y + a*(2^N-1-y)`, which is a linear interpolation scaled by roughly 2^N.

The loop always runs N steps. It does not stop early on a zero weight. After the last step, a fix-up stage turns the 2N-bit sum into an N-bit fraction: it takes the upper N bits and adds their top bit into their bottom bit. A client pulses `startIn` for one cycle with the operands while the unit is idle. It then waits for the one-cycle `doneOut` pulse and reads the N-bit result and the raw 2N-bit sum. Both outputs hold their values until the next operation completes.

Top module: `lerp_interp`

## Requirements
- R1: While reset is held and just after it is released, `busyOut` and `doneOut` are 0 and `resultOut` and `rawOut` are 0.
- R2: A `startIn` pulse taken while `busyOut` is 0 captures `aIn`, `bIn` and `yIn` at that clock edge. `busyOut` is 1 from the next cycle onward for exactly N+1 cycles.
- R3: `doneOut` is a single-cycle pulse in the (N+1)th cycle after the accepting edge. `busyOut` is 0 in that same cycle.
- R4: The run length is the same for every weight, including a weight of zero. The loop always runs N steps.
- R5: `rawOut` equals the sum over i of (`yIn` bit i ? `bIn` : `aIn`) times 2^i, taken over N bits of weight. This is equal to `b*y + a*(2^N-1-y)` in 2N bits.
- R6: With weight 0, `rawOut` equals `a*(2^N-1)`. With weight all ones, it equals `b*(2^N-1)`.
- R7: `resultOut` equals `rawOut[2N-1:N] + rawOut[2N-1]`, truncated to N bits.
- R8: With N=16 and a = b = y = 0xFFFF, `rawOut` is 0xFFFE0001 and `resultOut` is 0xFFFF.
- R9: A `startIn` pulse while `busyOut` is 1 is ignored. The running operation keeps its operands and its timing.
- R10: `resultOut` and `rawOut` keep their values in every cycle in which `doneOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start request, taken only while idle |
| aIn | input | N | Fraction chosen when the weight bit is 0 |
| bIn | input | N | Fraction chosen when the weight bit is 1 |
| yIn | input | N | Interpolation weight |
| busyOut | output | 1 | Operation in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| resultOut | output | N | Renormalised N-bit fraction |
| rawOut | output | 2N | Raw 2N-bit accumulated sum |

## Verification
A fault in the step counter changes when `doneOut` arrives. It shows at the ports within one run as a pulse before or after cycle N+1, or as a `busyOut` window of the wrong length. A wrong select, shift or add inside the datapath leaves timing intact. It corrupts `rawOut` at the next completion, and usually `resultOut` with it. Some faults need a particular bit pattern to show: a swapped select appears only when `a` differs from `b`, and a dropped top-bit fix-up appears only when the upper half of the sum has its top bit set. The all-zero, all-one and full-scale weights each expose a different class of these faults, so the stimulus includes all three.

// File: rtl/lerp_pkg.sv
package lerp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } lerpState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic step;    // one select-add-shift step
    logic finish;  // publish raw sum and renormalised fraction
  } ctrlStrobes_t;

endpackage

// File: rtl/lerp_ctrl.sv
module lerp_ctrl
  import lerp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  output ctrlStrobes_t strobes,
  output logic         busyOut,
  output logic         doneOut
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

  lerpState_t    state;
  logic [CW-1:0] stepsLeft;
  logic          doneReg;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && startIn;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_FINISH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepsLeft <= '0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startIn) begin
            state     <= ST_RUN;
            stepsLeft <= LAST_STEP;
          end
        end
        ST_RUN: begin
          if (stepsLeft == '0) state <= ST_FINISH;
          else                 stepsLeft <= stepsLeft - 1'b1;
        end
        ST_FINISH: begin
          state   <= ST_IDLE;
          doneReg <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busyOut = (state != ST_IDLE);
  assign doneOut = doneReg;
endmodule

// File: rtl/lerp_datapath.sv
module lerp_datapath
  import lerp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobes_t   strobes,
  input  logic [N-1:0]   aIn,
  input  logic [N-1:0]   bIn,
  input  logic [N-1:0]   yIn,
  output logic [N-1:0]   resultOut,
  output logic [2*N-1:0] rawOut
);
  localparam int W = 2 * N;

  logic [W-1:0] accReg;
  logic [W-1:0] aShift;
  logic [W-1:0] bShift;
  logic [N-1:0] yShift;
  logic [W-1:0] addend;
  logic [N-1:0] upperHalf;
  logic [N-1:0] fixedUp;
  logic [N-1:0] resultReg;
  logic [W-1:0] rawReg;

  // One operand is always added: the weight bit only chooses which
  always_comb addend = yShift[0] ? bShift : aShift;

  // Fold the top bit of the upper half back into its bottom bit
  always_comb begin
    upperHalf = accReg[W-1:N];
    fixedUp   = upperHalf + N'(upperHalf[N-1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
      aShift <= '0;
      bShift <= '0;
      yShift <= '0;
    end else if (strobes.load) begin
      accReg <= '0;
      aShift <= W'(aIn);
      bShift <= W'(bIn);
      yShift <= yIn;
    end else if (strobes.step) begin
      accReg <= accReg + addend;
      aShift <= aShift << 1;
      bShift <= bShift << 1;
      yShift <= yShift >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg <= '0;
      rawReg    <= '0;
    end else if (strobes.finish) begin
      resultReg <= fixedUp;
      rawReg    <= accReg;
    end
  end

  assign resultOut = resultReg;
  assign rawOut    = rawReg;
endmodule

// File: rtl/lerp_interp.sv
module lerp_interp
  import lerp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startIn,
  input  logic [N-1:0]   aIn,
  input  logic [N-1:0]   bIn,
  input  logic [N-1:0]   yIn,
  output logic           busyOut,
  output logic           doneOut,
  output logic [N-1:0]   resultOut,
  output logic [2*N-1:0] rawOut
);
  ctrlStrobes_t strobes;

  lerp_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobes (strobes),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  lerp_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .aIn       (aIn),
    .bIn       (bIn),
    .yIn       (yIn),
    .resultOut (resultOut),
    .rawOut    (rawOut)
  );
endmodule

// File: rtl/lerp_interp_chk.sv
module lerp_interp_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           startIn,
  input logic           busyOut,
  input logic           doneOut,
  input logic [N-1:0]   resultOut,
  input logic [2*N-1:0] rawOut
);
  localparam int CW = $clog2(N + 3);
  logic [CW-1:0] sinceStart;

  // Cycles since the last accepted start, counted outside the design
  always_ff @(posedge clk) begin
    if (!rstN)                    sinceStart <= '0;
    else if (!busyOut && startIn) sinceStart <= '0;
    else if (busyOut)             sinceStart <= sinceStart + 1'b1;
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && startIn) |=> busyOut);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busyOut);

  p_busy_ends_in_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> doneOut);

  p_fixed_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (sinceStart == CW'(N + 1)));

  p_renorm_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (resultOut == N'(rawOut[2*N-1:N] + N'(rawOut[2*N-1]))));

  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> ($stable(resultOut) && $stable(rawOut)));
endmodule

bind lerp_interp lerp_interp_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startIn   (startIn),
  .busyOut   (busyOut),
  .doneOut   (doneOut),
  .resultOut (resultOut),
  .rawOut    (rawOut)
);

// File: tb/test_lerp_interp.sv
`timescale 1ns/1ps
module test_lerp_interp;
  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rstN;
  logic           startIn;
  logic [N-1:0]   aIn, bIn, yIn;
  logic           busyOut, doneOut;
  logic [N-1:0]   resultOut;
  logic [2*N-1:0] rawOut;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #4 clk = ~clk;

  lerp_interp #(.N(N)) i_lerp_interp (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .aIn(aIn), .bIn(bIn), .yIn(yIn),
    .busyOut(busyOut), .doneOut(doneOut),
    .resultOut(resultOut), .rawOut(rawOut)
  );

  // Closed form of the interpolation sum
  function automatic logic [2*N-1:0] expRaw(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] y);
    longint unsigned full = (64'd1 << N) - 1;
    return (2*N)'(longint'(b) * longint'(y) + longint'(a) * (full - longint'(y)));
  endfunction

  function automatic logic [N-1:0] expRes(logic [2*N-1:0] raw);
    logic [N-1:0] up = raw[2*N-1:N];
    return up + N'(up[N-1]);
  endfunction

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Runs one operation; optionally pulses a stray start in the middle (R9)
  task automatic runOp(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] y, bit poke, string req);
    logic [2*N-1:0] er;
    int badTiming = 0;
    er = expRaw(a, b, y);
    @(negedge clk);
    aIn = a; bIn = b; yIn = y; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    aIn = ~a; bIn = ~b; yIn = ~y;
    chk(busyOut == 1'b1, "R2", "busy after start", busyOut, 1);
    for (int k = 1; k <= N; k++) begin
      if (poke && k == 3) begin
        startIn = 1'b1; aIn = N'($urandom); bIn = N'($urandom); yIn = N'($urandom);
      end
      @(negedge clk);
      startIn = 1'b0;
      if (busyOut !== 1'b1 || doneOut !== 1'b0) badTiming++;
    end
    chk(badTiming == 0, poke ? "R9" : "R4", "busy window before done", badTiming, 0);
    @(negedge clk);
    chk(doneOut == 1'b1 && busyOut == 1'b0, "R3", "done at N+1", {busyOut, doneOut}, 1);
    chk(rawOut == er, req, "raw sum", rawOut, er);
    chk(resultOut == expRes(er), "R7", "renormalised result", resultOut, expRes(er));
    @(negedge clk);
    chk(doneOut == 1'b0, "R3", "done single cycle", doneOut, 0);
    @(negedge clk);
    chk(rawOut == er && resultOut == expRes(er), "R10", "outputs held", rawOut, er);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; startIn = 1'b0; aIn = '0; bIn = '0; yIn = '0;
    repeat (3) @(negedge clk);
    chk(busyOut == 0 && doneOut == 0 && resultOut == 0 && rawOut == 0, "R1", "reset state",
        {busyOut, doneOut, resultOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busyOut == 0 && doneOut == 0, "R1", "idle after reset", {busyOut, doneOut}, 0);

    runOp(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, "R8");
    chk(resultOut == 16'hFFFF, "R8", "full scale result", resultOut, 16'hFFFF);
    runOp(16'h1234, 16'hBEEF, 16'h0000, 1'b0, "R6");
    runOp(16'h0001, 16'h8000, 16'h0000, 1'b0, "R6");
    runOp(16'h4321, 16'hA5A5, 16'hFFFF, 1'b0, "R6");
    runOp(16'h0000, 16'hFFFF, 16'h8000, 1'b0, "R5");
    runOp(16'hFFFF, 16'h0000, 16'h0001, 1'b0, "R5");
    runOp(16'h7F00, 16'h00FF, 16'hAAAA, 1'b1, "R9");
    for (int i = 0; i < 40; i++)
      runOp(N'($urandom), N'($urandom), N'($urandom), (i % 5) == 0, "R5");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule